// File: doc/BRIEF.md
# Dual-Tone Sample Synthesizer with Burst Sequencer

This block turns a 4-bit key code into a stream of digital dual-tone samples. It is clocked from a 3.579545 MHz reference. Two identical tone channels each hold a segment divider and a 5-bit phase counter. A tone period always has 32 phase steps, so the length of a step alone sets the frequency. The code selects one low-group divider and one high-group divider. The two channel outputs are weighted 4:5, about 2 dB in favour of the high group, summed and offset to mid-scale. The result is registered on `sample_o`, ready for an external converter.

A burst sequencer sits between the host write strobe and the channels. With bursts disabled, a written code takes effect on the next clock and the tone sounds for as long as the tone enable is high. With bursts enabled, a written code is queued. The sequencer then plays one tone interval followed by one equal silent interval, and raises a one-cycle ready pulse at the end of the silence. Call-progress mode doubles both intervals. A code written while a burst runs stays queued until the next burst starts. The dividers never stop, so the tone phase carries on through silences and code changes.

Top module: `dtmf_burst_gen`

## Requirements
- R1: While reset is low and afterwards until something is written, `sample_o` is 2048, `tone_on_o` is 0 and `tx_ready_o` is 0. The code in use after reset is 0.
- R2: The code picks the low-group divider by key row: codes 1,2,3,13 give 160; 4,5,6,14 give 146; 7,8,9,15 give 132; 10,11,12,0 give 118 clocks per step. It picks the high-group divider by key column: codes 1,4,7,11 give 92; 2,5,8,10 give 84; 3,6,9,12 give 76; 13,14,15,0 give 68.
- R3: Each channel counts clocks from 0 and advances its 5-bit phase by one when the count is at or above its divider minus one, then restarts from 0. A full tone period is therefore 32 steps. The dividers and phases run at all times, including while the output is silent.
- R4: When the tone is gated on, each clock loads `sample_o` with 2048 + 4*S(row phase) + 5*S(column phase), using the phases held before that edge, where S(k) = round(127*sin(2*pi*k/32)).
- R5: When the tone is gated off, the next `sample_o` is exactly 2048.
- R6: The gate, seen on `tone_on_o`, is `tone_en_i` AND (NOT `burst_en_i` OR tone interval active). In burst mode the tone interval and the pause that follows each last BURST_CYC clocks, or 2*BURST_CYC clocks when `cp_mode_i` is 1.
- R7: `tx_ready_o` pulses for exactly one cycle, in the cycle after a pause interval completes, and at no other time.
- R8: In burst mode a write is queued. A burst starts only from a queued code, one clock after the sequencer is idle with a code queued. A write made during a burst is played by the next burst and does not alter the running one.
- R9: With `burst_en_i` low, a write is used by the dividers from the next clock, and `tone_on_o` follows `tone_en_i`.
- R10: Lowering `tone_en_i` or `burst_en_i` ends a running burst at once, with no ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, 3.579545 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_wr_i | input | 1 | Write strobe for the transmit code |
| tx_code_i | input | 4 | Key code to transmit |
| tone_en_i | input | 1 | Tone output enable |
| burst_en_i | input | 1 | Selects timed burst/pause operation |
| cp_mode_i | input | 1 | Doubles the burst and pause intervals |
| sample_o | output | SAMPLE_W | Unsigned summed tone sample, mid-scale when silent |
| tone_on_o | output | 1 | Tone gate currently open |
| tx_ready_o | output | 1 | One-cycle pulse when a pause has ended |

## Verification
The hardest case to reach is a write that arrives during a running burst, because it must stay invisible until the following burst and must then start that burst with no new write. The directed sequence waits until the tone rises and writes a second code a few cycles into the tone interval. It then counts the tone and pause cycles of the first burst, and checks that a second burst starts right after the ready pulse and that nothing follows it. A cycle-level reference model that runs beside the design catches any phase slip across gated and ungated stretches. Random stimulus is also used, toggling enable, mode and burst select at random while codes are written.

// File: rtl/dtmf_synth_pkg.sv
package dtmf_synth_pkg;

  localparam int PH_W  = 5;
  localparam int DIV_W = 8;
  localparam int AMP_W = 8;

  typedef enum logic [1:0] {BS_IDLE, BS_TONE, BS_GAP} burst_st_e;

  // key row of a code
  function automatic logic [1:0] row_sel(input logic [3:0] c);
    case (c)
      4'd1, 4'd2, 4'd3, 4'd13:  row_sel = 2'd0;
      4'd4, 4'd5, 4'd6, 4'd14:  row_sel = 2'd1;
      4'd7, 4'd8, 4'd9, 4'd15:  row_sel = 2'd2;
      default:                  row_sel = 2'd3;
    endcase
  endfunction

  // key column of a code
  function automatic logic [1:0] col_sel(input logic [3:0] c);
    case (c)
      4'd1, 4'd4, 4'd7, 4'd11:  col_sel = 2'd0;
      4'd2, 4'd5, 4'd8, 4'd10:  col_sel = 2'd1;
      4'd3, 4'd6, 4'd9, 4'd12:  col_sel = 2'd2;
      default:                  col_sel = 2'd3;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] row_div(input logic [1:0] s);
    case (s)
      2'd0:    row_div = DIV_W'(160);
      2'd1:    row_div = DIV_W'(146);
      2'd2:    row_div = DIV_W'(132);
      default: row_div = DIV_W'(118);
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] col_div(input logic [1:0] s);
    case (s)
      2'd0:    col_div = DIV_W'(92);
      2'd1:    col_div = DIV_W'(84);
      2'd2:    col_div = DIV_W'(76);
      default: col_div = DIV_W'(68);
    endcase
  endfunction

  // 32-step sine from a quarter wave, amplitude 127
  function automatic logic signed [AMP_W-1:0] sine_at(input logic [PH_W-1:0] ph);
    logic [3:0] h;
    logic [3:0] q;
    logic signed [AMP_W-1:0] m;
    h = ph[3:0];
    q = (h > 4'd8) ? 4'(5'd16 - {1'b0, h}) : h;
    case (q)
      4'd0:    m = 8'sd0;
      4'd1:    m = 8'sd25;
      4'd2:    m = 8'sd49;
      4'd3:    m = 8'sd71;
      4'd4:    m = 8'sd90;
      4'd5:    m = 8'sd106;
      4'd6:    m = 8'sd117;
      4'd7:    m = 8'sd125;
      default: m = 8'sd127;
    endcase
    sine_at = ph[4] ? -m : m;
  endfunction

endpackage

// File: rtl/dtmf_tone_chan.sv
module dtmf_tone_chan
  import dtmf_synth_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DIV_W-1:0]        seg_len_i,
  output logic signed [AMP_W-1:0] amp_o
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] seg_cnt_q;
  logic [PH_W-1:0]  phase_q;
  logic             seg_end;

  // >= so a shorter divider after a code change wraps at once
  assign seg_end = seg_cnt_q >= (seg_len_i - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_cnt_q <= '0;
      phase_q   <= '0;
    end else if (seg_end) begin
      seg_cnt_q <= '0;
      phase_q   <= phase_q + 1'b1;
    end else begin
      seg_cnt_q <= seg_cnt_q + ONE;
    end
  end

  assign amp_o = sine_at(phase_q);

  p_phase_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != $past(phase_q)) |-> (phase_q == $past(phase_q) + 1'b1));

  p_cnt_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != $past(phase_q)) |-> (seg_cnt_q == '0));

endmodule

// File: rtl/dtmf_burst_seq.sv
module dtmf_burst_seq
  import dtmf_synth_pkg::*;
#(
  parameter int BURST_CYC = 182557
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [3:0] code_i,
  input  logic       tone_en_i,
  input  logic       burst_en_i,
  input  logic       cp_mode_i,
  output logic [3:0] code_o,
  output logic       gate_o,
  output logic       ready_o
);

  localparam int TMR_W = $clog2(2 * BURST_CYC);
  localparam logic [TMR_W-1:0] LAST_STD = TMR_W'(BURST_CYC - 1);
  localparam logic [TMR_W-1:0] LAST_EXT = TMR_W'(2 * BURST_CYC - 1);

  burst_st_e        st_q;
  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W-1:0] last_w;
  logic [3:0]       act_q, pend_q;
  logic             pend_vld_q, ready_q;
  logic             run_ok;

  assign last_w = cp_mode_i ? LAST_EXT : LAST_STD;
  assign run_ok = burst_en_i && tone_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= BS_IDLE;
      tmr_q      <= '0;
      act_q      <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      ready_q    <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      if (!run_ok) begin
        st_q  <= BS_IDLE;
        tmr_q <= '0;
      end else begin
        case (st_q)
          BS_IDLE: if (pend_vld_q) begin
            st_q       <= BS_TONE;
            tmr_q      <= '0;
            act_q      <= pend_q;
            pend_vld_q <= 1'b0;
          end
          BS_TONE: if (tmr_q >= last_w) begin
            st_q  <= BS_GAP;
            tmr_q <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
          BS_GAP: if (tmr_q >= last_w) begin
            st_q    <= BS_IDLE;
            tmr_q   <= '0;
            ready_q <= 1'b1;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
          default: st_q <= BS_IDLE;
        endcase
      end
      // later assignment wins: a write on a start cycle queues for the next burst
      if (wr_i) begin
        if (burst_en_i) begin
          pend_q     <= code_i;
          pend_vld_q <= 1'b1;
        end else begin
          act_q <= code_i;
        end
      end
    end
  end

  assign code_o  = act_q;
  assign gate_o  = tone_en_i && (!burst_en_i || (st_q == BS_TONE));
  assign ready_o = ready_q;

  p_tmr_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q <= LAST_EXT);

  p_ready_after_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |-> ($past(st_q) == BS_GAP));

  p_ready_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> !ready_q);

  p_code_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q != BS_IDLE) && ($past(st_q) != BS_IDLE)) |-> $stable(act_q));

  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_ok) |-> (st_q == BS_IDLE));

endmodule

// File: rtl/dtmf_burst_gen.sv
module dtmf_burst_gen
  import dtmf_synth_pkg::*;
#(
  parameter int BURST_CYC = 182557,
  parameter int SAMPLE_W  = 12,
  parameter int LOW_WT    = 4,
  parameter int HIGH_WT   = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tx_wr_i,
  input  logic [3:0]          tx_code_i,
  input  logic                tone_en_i,
  input  logic                burst_en_i,
  input  logic                cp_mode_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                tone_on_o,
  output logic                tx_ready_o
);

  localparam int MID    = 1 << (SAMPLE_W - 1);
  localparam int SWING  = 127 * (LOW_WT + HIGH_WT);
  localparam int N_CHAN = 2;
  localparam int SUM_W  = SAMPLE_W + 1;

  logic [3:0]              act_code;
  logic                    gate;
  logic [DIV_W-1:0]        seg_len [N_CHAN];
  logic signed [AMP_W-1:0] amp     [N_CHAN];
  logic signed [SUM_W-1:0] lo_term, hi_term, mix;
  logic [SAMPLE_W-1:0]     sample_q, sample_d;

  dtmf_burst_seq #(.BURST_CYC(BURST_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (tx_wr_i),
    .code_i     (tx_code_i),
    .tone_en_i  (tone_en_i),
    .burst_en_i (burst_en_i),
    .cp_mode_i  (cp_mode_i),
    .code_o     (act_code),
    .gate_o     (gate),
    .ready_o    (tx_ready_o)
  );

  // channel 0 = low group, channel 1 = high group
  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    if (g == 0) begin : g_low
      assign seg_len[g] = row_div(row_sel(act_code));
    end else begin : g_high
      assign seg_len[g] = col_div(col_sel(act_code));
    end
    dtmf_tone_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .seg_len_i (seg_len[g]),
      .amp_o     (amp[g])
    );
  end

  always_comb begin
    lo_term  = SUM_W'(amp[0]) * SUM_W'(LOW_WT);
    hi_term  = SUM_W'(amp[1]) * SUM_W'(HIGH_WT);
    mix      = lo_term + hi_term + SUM_W'(MID);
    sample_d = SAMPLE_W'(mix);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_q <= SAMPLE_W'(MID);
    else         sample_q <= gate ? sample_d : SAMPLE_W'(MID);
  end

  assign sample_o  = sample_q;
  assign tone_on_o = gate;

  p_mid_when_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(gate) |-> (sample_q == SAMPLE_W'(MID)));

  p_sample_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_q >= SAMPLE_W'(MID - SWING)) && (sample_q <= SAMPLE_W'(MID + SWING)));

  p_gate_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_en_i |-> (tone_on_o == tone_en_i));

endmodule

// File: tb/sim_dtmf_burst_gen.sv
`timescale 1ns/1ps
module sim_dtmf_burst_gen;

  localparam int BC = 37;
  localparam int MIDV = 2048;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_wr_i = 1'b0;
  logic [3:0] tx_code_i = '0;
  logic       tone_en_i = 1'b0;
  logic       burst_en_i = 1'b0;
  logic       cp_mode_i = 1'b0;
  logic [11:0] sample_o;
  logic       tone_on_o;
  logic       tx_ready_o;

  int n_run = 0;
  int n_fail = 0;
  bit mon_en = 1'b0;
  string cur_tag = "R4 sample";

  always #4 clk_i = ~clk_i;

  dtmf_burst_gen #(.BURST_CYC(BC)) u0 (
    .clk_i, .rst_ni, .tx_wr_i, .tx_code_i, .tone_en_i,
    .burst_en_i, .cp_mode_i, .sample_o, .tone_on_o, .tx_ready_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bsin(input int k);
    real r;
    r = 127.0 * $sin(2.0 * 3.14159265358979 * k / 32.0);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  // keypad: rows 697/770/852/941, columns 1209/1336/1477/1633
  function automatic int low_len(input int c);
    case (c)
      1, 2, 3, 13: return 160;
      4, 5, 6, 14: return 146;
      7, 8, 9, 15: return 132;
      default:     return 118;
    endcase
  endfunction

  function automatic int high_len(input int c);
    case (c)
      1, 4, 7, 11: return 92;
      2, 5, 8, 10: return 84;
      3, 6, 9, 12: return 76;
      default:     return 68;
    endcase
  endfunction

  // reference model
  int m_st, m_tmr, m_act, m_pend, m_rdy, m_samp;
  bit m_pv;
  int m_cnt [2];
  int m_ph  [2];

  always @(posedge clk_i or negedge rst_ni) begin
    int len0, len1, last;
    bit g;
    if (!rst_ni) begin
      m_st = 0; m_tmr = 0; m_act = 0; m_pend = 0; m_pv = 0; m_rdy = 0;
      m_samp = MIDV;
      for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_ph[i] = 0; end
    end else begin
      g = tone_en_i && (!burst_en_i || m_st == 1);
      m_samp = g ? MIDV + 4 * bsin(m_ph[0]) + 5 * bsin(m_ph[1]) : MIDV;
      len0 = low_len(m_act);
      len1 = high_len(m_act);
      if (m_cnt[0] >= len0 - 1) begin m_cnt[0] = 0; m_ph[0] = (m_ph[0] + 1) % 32; end
      else m_cnt[0]++;
      if (m_cnt[1] >= len1 - 1) begin m_cnt[1] = 0; m_ph[1] = (m_ph[1] + 1) % 32; end
      else m_cnt[1]++;
      last = cp_mode_i ? 2 * BC - 1 : BC - 1;
      m_rdy = 0;
      if (!burst_en_i || !tone_en_i) begin
        m_st = 0; m_tmr = 0;
      end else if (m_st == 0) begin
        if (m_pv) begin m_st = 1; m_tmr = 0; m_act = m_pend; m_pv = 0; end
      end else if (m_tmr >= last) begin
        if (m_st == 2) m_rdy = 1;
        m_st = (m_st == 1) ? 2 : 0;
        m_tmr = 0;
      end else begin
        m_tmr++;
      end
      if (tx_wr_i) begin
        if (burst_en_i) begin m_pend = tx_code_i; m_pv = 1; end
        else m_act = tx_code_i;
      end
    end
  end

  always @(negedge clk_i) begin
    if (mon_en) begin
      chk({cur_tag, " sample"}, sample_o, m_samp);
      chk("R7 ready", tx_ready_o, m_rdy);
      chk("R6 gate", tone_on_o, tone_en_i && (!burst_en_i || m_st == 1));
    end
  end

  task automatic tick();
    @(negedge clk_i);
    #1;
  endtask

  task automatic wr(input int c);
    tx_code_i = 4'(c);
    tx_wr_i = 1'b1;
    tick();
    tx_wr_i = 1'b0;
  endtask

  // one burst: returns tone and pause lengths
  task automatic burst_len(input int c, output int hi, output int lo, input bit extra_wr);
    int w;
    wr(c);
    w = 0;
    while (!tone_on_o && w < 20) begin w++; tick(); end
    hi = 0;
    while (tone_on_o && hi < 1000) begin
      hi++;
      if (extra_wr && hi == 3) begin tx_code_i = 4'd9; tx_wr_i = 1'b1; end
      else tx_wr_i = 1'b0;
      tick();
    end
    tx_wr_i = 1'b0;
    lo = 0;
    while (!tx_ready_o && lo < 1000) begin lo++; tick(); end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int hi, lo, cnt;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) tick();
    chk("R1 reset sample", sample_o, MIDV);
    chk("R1 reset gate", tone_on_o, 0);
    chk("R1 reset ready", tx_ready_o, 0);
    rst_ni = 1'b1;
    tick();
    mon_en = 1'b1;
    repeat (20) tick();
    chk("R1 idle sample", sample_o, MIDV);
    chk("R5 silent sample", sample_o, MIDV);

    // non-burst sweep of every code
    cur_tag = "R2/R3 sweep";
    tone_en_i = 1'b1;
    for (int c = 0; c < 16; c++) begin
      wr(c);
      chk("R9 tone on", tone_on_o, 1);
      repeat (2500) tick();
    end
    tone_en_i = 1'b0;
    tick();
    tick();
    chk("R5 mid after gate off", sample_o, MIDV);

    // burst with a write during the tone
    cur_tag = "R4 burst";
    burst_en_i = 1'b1;
    tone_en_i = 1'b1;
    tick();
    burst_len(5, hi, lo, 1'b1);
    chk("R6 tone cycles", hi, BC);
    chk("R6 pause cycles", lo, BC);
    chk("R7 ready after pause", tx_ready_o, 1);
    tick();
    chk("R7 ready one cycle", tx_ready_o, 0);
    chk("R8 queued burst starts", tone_on_o, 1);
    cnt = 0;
    while (!tx_ready_o && cnt < 1000) begin cnt++; tick(); end
    chk("R8 queued burst length", cnt, 2 * BC);
    cnt = 0;
    for (int i = 0; i < 3 * BC; i++) begin
      tick();
      if (tone_on_o || tx_ready_o) cnt++;
    end
    chk("R8 no burst without write", cnt, 0);

    // extended intervals
    cp_mode_i = 1'b1;
    tick();
    burst_len(12, hi, lo, 1'b0);
    chk("R6 cp tone cycles", hi, 2 * BC);
    chk("R6 cp pause cycles", lo, 2 * BC);
    cp_mode_i = 1'b0;
    repeat (3) tick();

    // abort
    wr(3);
    cnt = 0;
    while (!tone_on_o && cnt < 20) begin cnt++; tick(); end
    repeat (5) tick();
    tone_en_i = 1'b0;
    tick();
    chk("R10 abort gate", tone_on_o, 0);
    tone_en_i = 1'b1;
    cnt = 0;
    for (int i = 0; i < 3 * BC; i++) begin
      tick();
      if (tx_ready_o || tone_on_o) cnt++;
    end
    chk("R10 no ready after abort", cnt, 0);

    // random mix
    cur_tag = "R4 random";
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(49) == 0) begin
        tx_code_i = 4'($urandom_range(15));
        tx_wr_i = 1'b1;
      end else begin
        tx_wr_i = 1'b0;
      end
      if ($urandom_range(299) == 0) tone_en_i = ~tone_en_i;
      if ($urandom_range(399) == 0) burst_en_i = ~burst_en_i;
      if ($urandom_range(499) == 0) cp_mode_i = ~cp_mode_i;
      tick();
    end
    tx_wr_i = 1'b0;
    tick();
    mon_en = 1'b0;
    summary();
    $finish;
  end

endmodule